// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when a small controller core runs, naps or shuts down. It has four states. In the running state all clocks are on. In the napping state only the instruction clock is off. In the shut-down state the oscillator is off as well. The fourth state is a settling wait in which the oscillator runs for a fixed number of cycles before any gated clock is turned on again. The CPU decoder raises one-cycle nap or shut-down requests. The sequencer turns these into three gate enables (CPU clock, peripheral clock, oscillator). It also gives the core a strobe once per instruction cycle.

A nap ends when any pending, unmasked interrupt request appears, whatever the state of the global interrupt enable. The sequencer then pulses a resume signal so that the CPU carries on after the nap instruction. A shut-down ends only through the asynchronous reset or the stop-clear input. Either one passes through the settling wait, and the core then restarts at address 0, flagged by a restart pulse. A RAM-valid flag records how the last shut-down was left: 1 if it was left through stop-clear, 0 after any reset.

A nap or shut-down request is dropped if it arrives while interrupts are globally disabled and some unmasked request is already pending. This keeps the core from sleeping past an event it will never service.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are held at once as follows: `osc_en`=1, `cpu_clk_en`=0, `per_clk_en`=0, `ram_valid`=0. After release, all enables come on at the `STAB_CYC`-th rising edge. `exec_restart` is high for exactly that first running cycle.
- R2: In the running state, `{cpu_clk_en,per_clk_en,osc_en}`=111. A `sleep_req` that is not cancelled gives 011 from the next cycle on.
- R3: A `stop_req` that is not cancelled gives 000 from the next cycle on. If both requests are high in the same cycle, the shut-down request wins.
- R4: In the napping state, any nonzero `irq_act` returns the block to 111 on the next cycle, with `resume_pulse` high for that one cycle. `gie` has no effect on this.
- R5: `stopc` has no effect in the running or napping states. The enables and `ram_valid` are unchanged while it is held.
- R6: In the shut-down state, `irq_act` has no effect. `sleep_req` and `stop_req` have no effect outside the running state.
- R7: `stopc` high in the shut-down state gives 001 on the next cycle. The block then waits `STAB_CYC` more rising edges, enters 111, and pulses `exec_restart` for one cycle.
- R8: `ram_valid` becomes 1 on the cycle that leaves the shut-down state through `stopc`. It is cleared only by reset.
- R9: A request arriving while `gie`=0 and `irq_act` is nonzero is dropped, and the block stays at 111. With `gie`=1 the same request is carried out.
- R10: While running, `cyc_stb` is high on every `DIV`-th cycle, first on the `DIV`-th running cycle. It is never high while `cpu_clk_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Decoded nap request, one cycle |
| stop_req | input | 1 | Decoded shut-down request, one cycle |
| gie | input | 1 | Global interrupt enable |
| irq_act | input | NIRQ | Per-source request-and-not-masked bits |
| stopc | input | 1 | Stop-clear wake input, active high |
| cpu_clk_en | output | 1 | Instruction clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| ram_valid | output | 1 | Last shut-down was left through stop-clear |
| resume_pulse | output | 1 | One-cycle pulse on wake from nap |
| exec_restart | output | 1 | One-cycle pulse on restart at address 0 |
| cyc_stb | output | 1 | Instruction-cycle strobe |

## Verification
A wrong state register shows up at once as a wrong triple of enables. A missed transition is therefore seen at the first negative edge after the stimulus edge. A fault in the settling counter shifts the rise of `cpu_clk_en` and `exec_restart` by one or more cycles, so the bench samples on both sides of the expected edge. A stuck or misplaced flag shows up as a missing or stray `resume_pulse`, a `ram_valid` that does not clear on reset, or a strobe whose period differs from `DIV`. The divider is swept over several periods to catch that last fault.

// File: rtl/pms_pkg.sv
package pms_pkg;
    typedef enum logic [1:0] {
        PM_WAKE    = 2'd0,
        PM_ACTIVE  = 2'd1,
        PM_STANDBY = 2'd2,
        PM_STOP    = 2'd3
    } pm_state_e;
endpackage

// File: rtl/pms_stab_timer.sv
module pms_stab_timer #(
    parameter int unsigned STAB_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic last
);
    localparam int unsigned CW = $clog2(STAB_CYC + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(STAB_CYC);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = LOAD_VAL;
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LOAD_VAL;
        else        cnt_q <= cnt_d;
    end

    // the settling edge: the counter leaves 1 on this clock
    assign last = run && (cnt_q == ONE);
endmodule

// File: rtl/pms_cyc_div.sv
module pms_cyc_div #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic stb
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);
    localparam logic [PW-1:0] ONE = PW'(1);

    logic [PW-1:0] ph_d, ph_q;

    always_comb begin
        if (!run)              ph_d = '0;
        else if (ph_q == LAST) ph_d = '0;
        else                   ph_d = ph_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign stb = run && (ph_q == LAST);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
    parameter int unsigned NIRQ     = 7,
    parameter int unsigned STAB_CYC = 16,
    parameter int unsigned DIV      = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req,
    input  logic            stop_req,
    input  logic            gie,
    input  logic [NIRQ-1:0] irq_act,
    input  logic            stopc,
    output logic            cpu_clk_en,
    output logic            per_clk_en,
    output logic            osc_en,
    output logic            ram_valid,
    output logic            resume_pulse,
    output logic            exec_restart,
    output logic            cyc_stb
);
    import pms_pkg::*;

    typedef struct packed {
        pm_state_e st;
        logic      ram;
        logic      resume;
        logic      restart;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: PM_WAKE, ram: 1'b0, resume: 1'b0, restart: 1'b0};

    seq_t s_d, s_q;
    logic any_irq, cancel, tmr_load, tmr_run, tmr_last, run_active;

    assign any_irq  = |irq_act;
    assign cancel   = !gie && any_irq;
    assign tmr_load = (s_q.st == PM_STOP) && stopc;
    assign tmr_run  = (s_q.st == PM_WAKE);

    pms_stab_timer #(.STAB_CYC(STAB_CYC)) u_stab (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .run   (tmr_run),
        .last  (tmr_last)
    );

    always_comb begin
        s_d         = s_q;
        s_d.resume  = 1'b0;
        s_d.restart = 1'b0;
        unique case (s_q.st)
            PM_WAKE: begin
                if (tmr_last) begin
                    s_d.st      = PM_ACTIVE;
                    s_d.restart = 1'b1;
                end
            end
            PM_ACTIVE: begin
                if ((stop_req || sleep_req) && !cancel)
                    s_d.st = stop_req ? PM_STOP : PM_STANDBY;
            end
            PM_STANDBY: begin
                if (any_irq) begin
                    s_d.st     = PM_ACTIVE;
                    s_d.resume = 1'b1;
                end
            end
            PM_STOP: begin
                if (stopc) begin
                    s_d.st  = PM_WAKE;
                    s_d.ram = 1'b1;
                end
            end
            default: s_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RST;
        else        s_q <= s_d;
    end

    assign run_active = (s_q.st == PM_ACTIVE);

    pms_cyc_div #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_active),
        .stb   (cyc_stb)
    );

    assign cpu_clk_en   = run_active;
    assign per_clk_en   = run_active || (s_q.st == PM_STANDBY);
    assign osc_en       = (s_q.st != PM_STOP);
    assign ram_valid    = s_q.ram;
    assign resume_pulse = s_q.resume;
    assign exec_restart = s_q.restart;
endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
    parameter int unsigned NIRQ = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sleep_req,
    input logic            stop_req,
    input logic            gie,
    input logic [NIRQ-1:0] irq_act,
    input logic            stopc,
    input logic            cpu_clk_en,
    input logic            per_clk_en,
    input logic            osc_en,
    input logic            ram_valid,
    input logic            resume_pulse,
    input logic            exec_restart,
    input logic            cyc_stb
);
    logic nap, cancel;
    assign nap    = !cpu_clk_en && per_clk_en;
    assign cancel = !gie && (|irq_act);

    assert_gate_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en |-> (per_clk_en && osc_en)) and (per_clk_en |-> osc_en));

    assert_stop_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && stop_req && !cancel) |=> (!osc_en && !per_clk_en));

    assert_nap_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (nap && (|irq_act)) |=> (cpu_clk_en && resume_pulse));

    assert_nap_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nap && !(|irq_act)) |=> nap);

    assert_stop_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !stopc) |=> !osc_en);

    assert_stopc_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && stopc) |=> (osc_en && !per_clk_en && !cpu_clk_en));

    assert_ram_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_valid) |-> $past(!osc_en && stopc));

    assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && (sleep_req || stop_req) && cancel) |=> cpu_clk_en);

    assert_stb_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_stb |-> cpu_clk_en);

    assert_restart_after_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
        exec_restart |-> (cpu_clk_en && $past(osc_en && !per_clk_en)));

    assert_resume_after_nap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> (cpu_clk_en && $past(nap)));
endmodule

bind pwr_mode_seq pms_checker #(.NIRQ(NIRQ)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .stop_req     (stop_req),
    .gie          (gie),
    .irq_act      (irq_act),
    .stopc        (stopc),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .osc_en       (osc_en),
    .ram_valid    (ram_valid),
    .resume_pulse (resume_pulse),
    .exec_restart (exec_restart),
    .cyc_stb      (cyc_stb)
);

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;
    localparam int NIRQ = 7;
    localparam int STAB = 5;
    localparam int DIV  = 4;
    localparam logic [2:0] G_ACT = 3'b111, G_SBY = 3'b011, G_STP = 3'b000, G_WK = 3'b001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0, stop_req = 1'b0, gie = 1'b0, stopc = 1'b0;
    logic [NIRQ-1:0] irq_act = '0;
    logic cpu_clk_en, per_clk_en, osc_en, ram_valid, resume_pulse, exec_restart, cyc_stb;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwr_mode_seq #(.NIRQ(NIRQ), .STAB_CYC(STAB), .DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stop_req(stop_req),
        .gie(gie), .irq_act(irq_act), .stopc(stopc),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .ram_valid(ram_valid), .resume_pulse(resume_pulse),
        .exec_restart(exec_restart), .cyc_stb(cyc_stb)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic gates(input string req, input logic [2:0] exp);
        chk(req, "gates", {29'd0, cpu_clk_en, per_clk_en, osc_en}, {29'd0, exp});
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_sleep(input string req);
        sleep_req = 1'b1;
        wait_n(1);
        sleep_req = 1'b0;
        gates(req, G_SBY);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then settling wait
        wait_n(3);
        gates("R1", G_WK);
        chk("R8", "ram_valid in reset", 32'(ram_valid), 0);
        chk("R1", "restart in reset", 32'(exec_restart), 0);
        rst_n = 1'b1;
        wait_n(STAB - 1);
        gates("R1", G_WK);
        wait_n(1);
        gates("R1", G_ACT);
        chk("R1", "restart pulse", 32'(exec_restart), 1);
        chk("R8", "ram after reset", 32'(ram_valid), 0);

        // R10: strobe period sweep from first running cycle
        for (int k = 1; k <= 3 * DIV; k++) begin
            chk("R10", "cyc_stb", 32'(cyc_stb), 32'((k % DIV) == 0));
            if (k == 2) chk("R1", "restart single", 32'(exec_restart), 0);
            wait_n(1);
        end

        // R2 nap, R5 stopc ignored, R6 stop_req ignored in nap
        do_sleep("R2");
        chk("R10", "no stb in nap", 32'(cyc_stb), 0);
        stopc = 1'b1;
        wait_n(3);
        gates("R5", G_SBY);
        stopc = 1'b0;
        stop_req = 1'b1;
        wait_n(2);
        stop_req = 1'b0;
        gates("R6", G_SBY);

        // R4: wake sweep over each source, gie alternating
        for (int i = 0; i < NIRQ; i++) begin
            gie = i[0];
            irq_act = NIRQ'(1) << i;
            wait_n(1);
            gates("R4", G_ACT);
            chk("R4", "resume", 32'(resume_pulse), 1);
            irq_act = '0;
            wait_n(1);
            chk("R4", "resume single", 32'(resume_pulse), 0);
            do_sleep("R2");
        end
        irq_act = '1;
        wait_n(1);
        irq_act = '0;
        gates("R4", G_ACT);
        wait_n(1);

        // R9: cancellation sweep
        gie = 1'b0;
        for (int i = 0; i < NIRQ; i++) begin
            irq_act = NIRQ'(1) << i;
            if (i % 2 == 1) stop_req = 1'b1; else sleep_req = 1'b1;
            wait_n(1);
            stop_req = 1'b0;
            sleep_req = 1'b0;
            gates("R9", G_ACT);
            wait_n(1);
            gates("R9", G_ACT);
        end
        gie = 1'b1;
        irq_act = NIRQ'(1);
        sleep_req = 1'b1;
        wait_n(1);
        sleep_req = 1'b0;
        gates("R9", G_SBY);
        wait_n(1);
        gates("R4", G_ACT);
        irq_act = '0;
        wait_n(1);

        // R3: both requests -> shut-down
        sleep_req = 1'b1;
        stop_req = 1'b1;
        wait_n(1);
        sleep_req = 1'b0;
        stop_req = 1'b0;
        gates("R3", G_STP);
        irq_act = '1;
        sleep_req = 1'b1;
        wait_n(3);
        sleep_req = 1'b0;
        gates("R6", G_STP);
        irq_act = '0;

        // R7/R8: stop-clear exit
        stopc = 1'b1;
        wait_n(1);
        stopc = 1'b0;
        gates("R7", G_WK);
        chk("R8", "ram set", 32'(ram_valid), 1);
        wait_n(STAB - 1);
        gates("R7", G_WK);
        wait_n(1);
        gates("R7", G_ACT);
        chk("R7", "restart", 32'(exec_restart), 1);
        chk("R7", "no resume", 32'(resume_pulse), 0);

        // R5: stopc ignored while running
        stopc = 1'b1;
        wait_n(3);
        gates("R5", G_ACT);
        chk("R5", "ram kept", 32'(ram_valid), 1);
        stopc = 1'b0;
        wait_n(1);

        // R1/R8: reset from shut-down acts at once
        stop_req = 1'b1;
        wait_n(1);
        stop_req = 1'b0;
        gates("R3", G_STP);
        #1 rst_n = 1'b0;
        #1;
        gates("R1", G_WK);
        chk("R8", "ram cleared", 32'(ram_valid), 0);
        wait_n(2);
        rst_n = 1'b1;
        wait_n(STAB);
        gates("R1", G_ACT);
        chk("R8", "ram stays 0", 32'(ram_valid), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule